// File: doc/BRIEF.md
# Branch condition and target unit

This unit resolves control-flow requests for a 24-bit processor core. For a short conditional branch it tests a selectable predicate over the negative, zero, carry and overflow flags. It then returns either the relative target or the unchanged program counter, together with a taken indication. For calls, which are always taken, it forms the target from a 16-bit relative displacement or from a 16-bit register value. It also computes the lowered stack pointer and plays out the return-address words that must be written to the stack.

A request is presented for one cycle on `req_valid` with its kind, condition code, flags, PC, displacement, register value, stack pointer and page-zero mode bit. All branch offsets count halfwords: they are doubled before being added, the sum wraps within the program counter width, and bit 0 of a taken target is always zero. Stack writes leave the unit as a short sequence of push strobes, one per cycle, each with address and data, followed by a one-cycle done pulse. The unit accepts no new request until that sequence has finished.

Top module: `branch_target_unit`

## Requirements
- R1: For request kind 2'b00 (and 2'b11, which behaves identically) the offset is bits [7:0] of `disp` sign-extended and doubled, with bits [15:8] ignored. A taken target is `(pc_in + offset)` modulo 2^24 with bit 0 forced to 0.
- R2: Unsigned predicates: code 10 taken when !(Z|C), code 11 when (Z|C), code 4 when C, code 5 when !C.
- R3: Signed predicates: code 12 taken when !(N^V), code 13 when (N^V), code 14 when !((Z|N)^V), code 15 when ((Z|N)^V).
- R4: Single-flag and fixed predicates: code 2 on Z, 3 on !Z, 6 on N, 7 on !N, 8 on V, 9 on !V, code 0 always taken, code 1 never taken.
- R5: A branch whose predicate is false returns `next_pc` equal to `pc_in` unchanged and `taken` low.
- R6: Kind 2'b01 is a relative call: always taken, offset is the 16-bit signed `disp` doubled, and the target is wrapped to 24 bits with bit 0 cleared.
- R7: Kind 2'b10 is an indirect call: always taken, offset is `ireg` taken as unsigned and doubled.
- R8: A call with `page_zero` high lowers SP by 2. It issues exactly one push, with address the new SP and data `pc_in[15:0]`.
- R9: A call with `page_zero` low lowers SP by 4. It issues a push of `pc_in[15:0]` at the new SP, then on the next cycle a push of `{8'h00, pc_in[23:16]}` at new SP + 2, with 16-bit address wrap.
- R10: Results (`res_valid`, `next_pc`, `taken`, `new_sp`) appear in the cycle after acceptance. The first push appears in that same cycle, and `push_done` pulses for one cycle in the cycle after the last push.
- R11: While `busy` is high (from the first push through the done pulse) a request is ignored: no `res_valid` and no change of the held results.
- R12: A branch returns `new_sp` equal to `sp_in` and issues no push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_kind | input | 2 | 00/11 branch, 01 relative call, 10 indirect call |
| cond | input | 4 | Branch predicate code |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| pc_in | input | 24 | Current program counter |
| disp | input | 16 | Signed displacement (low byte for branches) |
| ireg | input | 16 | Register value for indirect calls |
| sp_in | input | 16 | Current stack pointer |
| page_zero | input | 1 | 1 selects 2-byte call frames |
| res_valid | output | 1 | Result strobe |
| next_pc | output | 24 | Resolved program counter |
| taken | output | 1 | Branch or call taken |
| new_sp | output | 16 | Stack pointer after the request |
| push_valid | output | 1 | Stack write strobe |
| push_addr | output | 16 | Stack write address |
| push_data | output | 16 | Stack write word |
| push_done | output | 1 | One-cycle pulse after the last push |
| busy | output | 1 | Push sequence in progress |

## Verification
The bench builds the unit with its default widths: a 24-bit program counter, a 16-bit stack pointer and 16-bit words. These leave an 8-bit upper PC byte for the second push word, so the word split can be checked. They also make wraparound reachable: a forward call from near the top of the PC space and a backward branch from near address zero both wrap. A stack pointer of 2 in four-byte mode wraps below zero, so the second push lands at address 0. All sixteen predicate codes are swept against all sixteen flag combinations.

// File: rtl/brc_pkg.sv
`timescale 1ns/1ps
package brc_pkg;

  typedef enum logic [1:0] {
    K_BRANCH     = 2'b00,
    K_CALL_REL   = 2'b01,
    K_CALL_IND   = 2'b10,
    K_BRANCH_ALT = 2'b11
  } req_kind_e;

  typedef enum logic [3:0] {
    C_ALWAYS = 4'd0,
    C_NEVER  = 4'd1,
    C_EQ     = 4'd2,
    C_NE     = 4'd3,
    C_CS     = 4'd4,
    C_CC     = 4'd5,
    C_MI     = 4'd6,
    C_PL     = 4'd7,
    C_VS     = 4'd8,
    C_VC     = 4'd9,
    C_HI     = 4'd10,
    C_LS     = 4'd11,
    C_GE     = 4'd12,
    C_LT     = 4'd13,
    C_GT     = 4'd14,
    C_LE     = 4'd15
  } cond_e;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_LO   = 2'd1,
    PS_HI   = 2'd2,
    PS_FIN  = 2'd3
  } push_st_e;

endpackage

// File: rtl/brc_cond_eval.sv
`timescale 1ns/1ps
module brc_cond_eval
  import brc_pkg::*;
(
  input  logic [3:0] cond,
  input  logic       fn,
  input  logic       fz,
  input  logic       fc,
  input  logic       fv,
  output logic       take
);

  logic lower_or_same;
  logic signed_less;
  logic signed_le;

  assign lower_or_same = fz | fc;
  assign signed_less   = fn ^ fv;
  assign signed_le     = (fz | fn) ^ fv;

  always_comb begin
    unique case (cond_e'(cond))
      C_ALWAYS: take = 1'b1;
      C_NEVER:  take = 1'b0;
      C_EQ:     take = fz;
      C_NE:     take = ~fz;
      C_CS:     take = fc;
      C_CC:     take = ~fc;
      C_MI:     take = fn;
      C_PL:     take = ~fn;
      C_VS:     take = fv;
      C_VC:     take = ~fv;
      C_HI:     take = ~lower_or_same;
      C_LS:     take = lower_or_same;
      C_GE:     take = ~signed_less;
      C_LT:     take = signed_less;
      C_GT:     take = ~signed_le;
      C_LE:     take = signed_le;
    endcase
  end

endmodule

// File: rtl/brc_target_calc.sv
`timescale 1ns/1ps
module brc_target_calc
  import brc_pkg::*;
#(
  parameter int PC_W    = 24,
  parameter int WORD_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic [1:0]        kind,
  input  logic [PC_W-1:0]   pc,
  input  logic [WORD_W-1:0] disp,
  input  logic [WORD_W-1:0] ireg,
  output logic [PC_W-1:0]   target
);

  logic [PC_W-1:0] halfword_off;
  logic [PC_W-1:0] sum;

  always_comb begin
    unique case (req_kind_e'(kind))
      K_CALL_REL: halfword_off = PC_W'($signed(disp));
      K_CALL_IND: halfword_off = PC_W'(ireg);
      default:    halfword_off = PC_W'($signed(disp[SHORT_W-1:0]));
    endcase
  end

  assign sum    = pc + (halfword_off << 1);
  assign target = {sum[PC_W-1:1], 1'b0};

endmodule

// File: rtl/brc_push_seq.sv
`timescale 1ns/1ps
module brc_push_seq
  import brc_pkg::*;
#(
  parameter int PC_W   = 24,
  parameter int SP_W   = 16,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              full_mode,
  input  logic [SP_W-1:0]   base_addr,
  input  logic [PC_W-1:0]   ret_pc,
  output logic              push_valid,
  output logic [SP_W-1:0]   push_addr,
  output logic [WORD_W-1:0] push_data,
  output logic              push_done,
  output logic              busy
);

  localparam int HI_W      = PC_W - WORD_W;
  localparam int WORD_STEP = WORD_W / 8;

  push_st_e          state_q, state_d;
  logic [SP_W-1:0]   addr_q;
  logic [PC_W-1:0]   pc_q;
  logic              full_q;
  logic [WORD_W-1:0] lo_word;
  logic [WORD_W-1:0] hi_word;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_IDLE: if (load) state_d = PS_LO;
      PS_LO:   state_d = full_q ? PS_HI : PS_FIN;
      PS_HI:   state_d = PS_FIN;
      PS_FIN:  state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      addr_q  <= '0;
      pc_q    <= '0;
      full_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load && (state_q == PS_IDLE)) begin
        addr_q <= base_addr;
        pc_q   <= ret_pc;
        full_q <= full_mode;
      end
    end
  end

  assign lo_word = pc_q[WORD_W-1:0];

  generate
    if (HI_W > 0) begin : g_hi_word
      assign hi_word = WORD_W'(pc_q[PC_W-1:WORD_W]);
    end else begin : g_no_hi_word
      assign hi_word = '0;
    end
  endgenerate

  assign push_valid = (state_q == PS_LO) || (state_q == PS_HI);
  assign push_addr  = (state_q == PS_HI) ? addr_q + SP_W'(WORD_STEP) : addr_q;
  assign push_data  = (state_q == PS_HI) ? hi_word : lo_word;
  assign push_done  = (state_q == PS_FIN);
  assign busy       = (state_q != PS_IDLE);

  assert_second_push_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && $past(push_valid)) |-> push_addr == SP_W'($past(push_addr) + SP_W'(WORD_STEP)));

  assert_done_after_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(push_valid) |-> push_done);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push_done |=> !push_done);

endmodule

// File: rtl/branch_target_unit.sv
`timescale 1ns/1ps
module branch_target_unit
  import brc_pkg::*;
#(
  parameter int PC_W   = 24,
  parameter int SP_W   = 16,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [3:0]        cond,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic              flag_v,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [WORD_W-1:0] disp,
  input  logic [WORD_W-1:0] ireg,
  input  logic [SP_W-1:0]   sp_in,
  input  logic              page_zero,
  output logic              res_valid,
  output logic [PC_W-1:0]   next_pc,
  output logic              taken,
  output logic [SP_W-1:0]   new_sp,
  output logic              push_valid,
  output logic [SP_W-1:0]   push_addr,
  output logic [WORD_W-1:0] push_data,
  output logic              push_done,
  output logic              busy
);

  localparam int SHORT_W    = 8;
  localparam int FRAME_PAGE = WORD_W / 8;
  localparam int FRAME_FULL = 2 * FRAME_PAGE;

  logic            rst_meta_q, rst_sync_q;
  logic            accept;
  logic            is_call;
  logic            cond_take;
  logic            taken_d;
  logic [PC_W-1:0] target;
  logic [PC_W-1:0] next_pc_d;
  logic [SP_W-1:0] new_sp_d;
  logic            res_valid_q, taken_q;
  logic [PC_W-1:0] next_pc_q;
  logic [SP_W-1:0] new_sp_q;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  brc_cond_eval u_cond (
    .cond (cond),
    .fn   (flag_n),
    .fz   (flag_z),
    .fc   (flag_c),
    .fv   (flag_v),
    .take (cond_take)
  );

  brc_target_calc #(
    .PC_W    (PC_W),
    .WORD_W  (WORD_W),
    .SHORT_W (SHORT_W)
  ) u_target (
    .kind   (req_kind),
    .pc     (pc_in),
    .disp   (disp),
    .ireg   (ireg),
    .target (target)
  );

  assign is_call   = (req_kind == K_CALL_REL) || (req_kind == K_CALL_IND);
  assign accept    = req_valid && !busy;
  assign taken_d   = is_call | cond_take;
  assign next_pc_d = taken_d ? target : pc_in;

  always_comb begin
    new_sp_d = sp_in;
    if (is_call) begin
      new_sp_d = page_zero ? sp_in - SP_W'(FRAME_PAGE) : sp_in - SP_W'(FRAME_FULL);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      res_valid_q <= 1'b0;
      taken_q     <= 1'b0;
      next_pc_q   <= '0;
      new_sp_q    <= '0;
    end else begin
      res_valid_q <= accept;
      if (accept) begin
        taken_q   <= taken_d;
        next_pc_q <= next_pc_d;
        new_sp_q  <= new_sp_d;
      end
    end
  end

  brc_push_seq #(
    .PC_W   (PC_W),
    .SP_W   (SP_W),
    .WORD_W (WORD_W)
  ) u_push (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .load       (accept && is_call),
    .full_mode  (~page_zero),
    .base_addr  (new_sp_d),
    .ret_pc     (pc_in),
    .push_valid (push_valid),
    .push_addr  (push_addr),
    .push_data  (push_data),
    .push_done  (push_done),
    .busy       (busy)
  );

  assign res_valid = res_valid_q;
  assign taken     = taken_q;
  assign next_pc   = next_pc_q;
  assign new_sp    = new_sp_q;

  assert_taken_even_R1: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (res_valid && taken) |-> !next_pc[0]);

  assert_untaken_keeps_pc_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (res_valid && !taken) |-> next_pc == $past(pc_in));

  assert_call_taken_R6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (res_valid && $past(is_call)) |-> taken);

  assert_page_frame_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (res_valid && $past(is_call && page_zero)) |-> new_sp == SP_W'($past(sp_in) - SP_W'(FRAME_PAGE)));

  assert_full_frame_R9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (res_valid && $past(is_call && !page_zero)) |-> new_sp == SP_W'($past(sp_in) - SP_W'(FRAME_FULL)));

  assert_first_push_with_result_R10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (res_valid && $past(is_call)) |-> (push_valid && push_addr == new_sp));

  assert_no_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_sync_q)
    res_valid |-> !$past(busy));

  assert_branch_keeps_sp_R12: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (res_valid && !$past(is_call)) |-> (new_sp == $past(sp_in) && !push_valid));

endmodule

// File: tb/sim_branch_target_unit.sv
`timescale 1ns/1ps
module sim_branch_target_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [3:0]  cond;
  logic        flag_n, flag_z, flag_c, flag_v;
  logic [23:0] pc_in;
  logic [15:0] disp;
  logic [15:0] ireg;
  logic [15:0] sp_in;
  logic        page_zero;
  logic        res_valid;
  logic [23:0] next_pc;
  logic        taken;
  logic [15:0] new_sp;
  logic        push_valid;
  logic [15:0] push_addr;
  logic [15:0] push_data;
  logic        push_done;
  logic        busy;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  branch_target_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .cond(cond), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .pc_in(pc_in), .disp(disp), .ireg(ireg), .sp_in(sp_in), .page_zero(page_zero),
    .res_valid(res_valid), .next_pc(next_pc), .taken(taken), .new_sp(new_sp),
    .push_valid(push_valid), .push_addr(push_addr), .push_data(push_data),
    .push_done(push_done), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // predicate model written from R2, R3, R4
  function automatic logic exp_take(input int cc, input logic n, z, c, v);
    case (cc)
      0: return 1'b1;
      1: return 1'b0;
      2: return z;
      3: return !z;
      4: return c;
      5: return !c;
      6: return n;
      7: return !n;
      8: return v;
      9: return !v;
      10: return !(z | c);
      11: return (z | c);
      12: return !(n ^ v);
      13: return (n ^ v);
      14: return !((z | n) ^ v);
      default: return ((z | n) ^ v);
    endcase
  endfunction

  function automatic string cond_req(input int cc);
    if (cc == 4 || cc == 5 || cc == 10 || cc == 11) return "R2";
    if (cc >= 12) return "R3";
    return "R4";
  endfunction

  // drive one request for one cycle; returns in the cycle after acceptance
  task automatic send(input logic [1:0] k, input logic [3:0] cc, input logic [3:0] nzcv,
                      input logic [23:0] pc, input logic [15:0] d, input logic [15:0] ir,
                      input logic [15:0] sp, input logic pz);
    req_valid = 1'b1; req_kind = k; cond = cc;
    {flag_n, flag_z, flag_c, flag_v} = nzcv;
    pc_in = pc; disp = d; ireg = ir; sp_in = sp; page_zero = pz;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 reset res_valid", 32'(res_valid), 32'd0);
    chk("R10 reset push_valid", 32'(push_valid), 32'd0);
    chk("R10 reset push_done", 32'(push_done), 32'd0);
    chk("R11 reset busy", 32'(busy), 32'd0);
  endtask

  task automatic t_branch_targets;
    send(2'b00, 4'd0, 4'h0, 24'h000200, 16'h007F, 16'h0, 16'h1000, 1'b0);
    chk("R10 res_valid", 32'(res_valid), 32'd1);
    chk("R1 forward max", 32'(next_pc), 32'h0002FE);
    send(2'b00, 4'd0, 4'h0, 24'h000200, 16'h0080, 16'h0, 16'h1000, 1'b0);
    chk("R1 backward max", 32'(next_pc), 32'h000100);
    send(2'b00, 4'd0, 4'h0, 24'h000010, 16'h00F0, 16'h0, 16'h1000, 1'b0);
    chk("R1 wrap below zero", 32'(next_pc), 32'hFFFFF0);
    send(2'b00, 4'd0, 4'h0, 24'h000101, 16'h0002, 16'h0, 16'h1000, 1'b0);
    chk("R1 bit0 cleared", 32'(next_pc), 32'h000104);
    send(2'b00, 4'd0, 4'h0, 24'h004000, 16'hAB05, 16'h0, 16'h1000, 1'b0);
    chk("R1 upper disp ignored", 32'(next_pc), 32'h00400A);
    send(2'b11, 4'd0, 4'h0, 24'h004000, 16'h00FF, 16'h0, 16'h1000, 1'b0);
    chk("R1 kind 11 as branch", 32'(next_pc), 32'h003FFE);
    chk("R1 kind 11 taken", 32'(taken), 32'd1);
  endtask

  task automatic t_conditions;
    for (int cc = 0; cc < 16; cc++) begin
      for (int f = 0; f < 16; f++) begin
        logic e;
        e = exp_take(cc, f[3], f[2], f[1], f[0]);
        send(2'b00, 4'(cc), 4'(f), 24'h001000, 16'h0010, 16'h0, 16'h2000, 1'b1);
        chk(cond_req(cc), 32'(taken), 32'(e));
        chk(e ? "R1 target" : "R5 untaken pc", 32'(next_pc), e ? 32'h001020 : 32'h001000);
      end
    end
    send(2'b00, 4'd1, 4'hF, 24'h000321, 16'h0040, 16'h0, 16'h2000, 1'b0);
    chk("R5 never keeps odd pc", 32'(next_pc), 32'h000321);
    chk("R5 never taken", 32'(taken), 32'd0);
  endtask

  task automatic t_branch_sp;
    send(2'b00, 4'd0, 4'h0, 24'h000800, 16'h0004, 16'h0, 16'h5555, 1'b0);
    chk("R12 sp kept", 32'(new_sp), 32'h5555);
    chk("R12 no push", 32'(push_valid), 32'd0);
    chk("R12 not busy", 32'(busy), 32'd0);
    @(negedge clk);
    chk("R12 no done", 32'(push_done), 32'd0);
  endtask

  task automatic t_call_page;
    send(2'b01, 4'd1, 4'h0, 24'h123456, 16'hFFFE, 16'h0, 16'h0400, 1'b1);
    chk("R6 taken", 32'(taken), 32'd1);
    chk("R6 target", 32'(next_pc), 32'h123452);
    chk("R8 new sp", 32'(new_sp), 32'h03FE);
    chk("R8 push valid", 32'(push_valid), 32'd1);
    chk("R8 push addr", 32'(push_addr), 32'h03FE);
    chk("R8 push data", 32'(push_data), 32'h3456);
    @(negedge clk);
    chk("R8 single push", 32'(push_valid), 32'd0);
    chk("R10 done", 32'(push_done), 32'd1);
    @(negedge clk);
    chk("R10 done one cycle", 32'(push_done), 32'd0);
    chk("R11 idle again", 32'(busy), 32'd0);
  endtask

  task automatic t_call_full_wrap;
    send(2'b01, 4'd1, 4'h0, 24'hFFFF00, 16'h0100, 16'h0, 16'h0002, 1'b0);
    chk("R6 target wrap", 32'(next_pc), 32'h000100);
    chk("R9 new sp wrap", 32'(new_sp), 32'hFFFE);
    chk("R9 push0 addr", 32'(push_addr), 32'hFFFE);
    chk("R9 push0 data", 32'(push_data), 32'hFF00);
    @(negedge clk);
    chk("R9 push1 valid", 32'(push_valid), 32'd1);
    chk("R9 push1 addr", 32'(push_addr), 32'h0000);
    chk("R9 push1 data", 32'(push_data), 32'h00FF);
    chk("R10 no early done", 32'(push_done), 32'd0);
    @(negedge clk);
    chk("R10 done after push1", 32'(push_done), 32'd1);
    chk("R9 two pushes only", 32'(push_valid), 32'd0);
    @(negedge clk);
  endtask

  task automatic t_call_indirect;
    send(2'b10, 4'd1, 4'h0, 24'h000010, 16'hFFFF, 16'h8000, 16'h1000, 1'b0);
    chk("R7 taken", 32'(taken), 32'd1);
    chk("R7 unsigned reg", 32'(next_pc), 32'h010010);
    chk("R9 new sp", 32'(new_sp), 32'h0FFC);
    chk("R9 push0 data", 32'(push_data), 32'h0010);
    @(negedge clk);
    chk("R9 push1 addr", 32'(push_addr), 32'h0FFE);
    chk("R9 push1 data", 32'(push_data), 32'h0000);
    @(negedge clk);
    chk("R10 done", 32'(push_done), 32'd1);
    @(negedge clk);
  endtask

  task automatic t_busy_ignore;
    send(2'b10, 4'd1, 4'h0, 24'h000200, 16'h0, 16'h0010, 16'h0800, 1'b0);
    chk("R7 target", 32'(next_pc), 32'h000220);
    chk("R11 busy", 32'(busy), 32'd1);
    // request during the push sequence
    send(2'b00, 4'd0, 4'h0, 24'h00AAAA, 16'h0002, 16'h0, 16'h1234, 1'b1);
    chk("R11 ignored no result", 32'(res_valid), 32'd0);
    chk("R11 pc held", 32'(next_pc), 32'h000220);
    chk("R11 sp held", 32'(new_sp), 32'h07FC);
    chk("R9 push1 unaffected", 32'(push_addr), 32'h07FE);
    @(negedge clk);
    chk("R10 done", 32'(push_done), 32'd1);
    chk("R11 still no result", 32'(res_valid), 32'd0);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'b00; cond = 4'd0;
    flag_n = 1'b0; flag_z = 1'b0; flag_c = 1'b0; flag_v = 1'b0;
    pc_in = '0; disp = '0; ireg = '0; sp_in = '0; page_zero = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_branch_targets();
    t_conditions();
    t_branch_sp();
    t_call_page();
    t_call_full_wrap();
    t_call_indirect();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule